// File: doc/BRIEF.md
# Cascadable Pixel Data Capture Register

This block is the input stage of one column driver in a chain of such drivers. A start token arrives on one of two start pins. From the next clock edge onward, each rising edge writes one 36-bit bus word into a wide data register. A bus word is six 6-bit dot codes, which is two RGB pixels. One load position holds one word, and the register has a parameterised number of positions (70 by default, which gives 420 channels).

A direction input chooses three things:
- which start pin the token is taken from;
- which pin passes the token on to the next driver;
- whether words fill the register from the low channel groups upward or from the high groups downward.

A few clocks before the register is full, the block sends a one-period pulse to the next driver in the chain. After a fixed number of clocks the block stops loading on its own. A rising edge on the line strobe ends the load sequence early. Each half of the bus has its own inversion control, which is applied as the word is stored.

Top module: `column_capture`

## Requirements
- R1: Dot d of a bus word occupies pix_in bits [6d+5:6d], with bit 6d as its LSB. A word stored in channel group g occupies row_data bits [36g+35:36g], and the dots keep the same order inside the group, so dot d lands at bits [36g+6d+5:36g+6d].
- R2: When dir_right is 1, only start_r_in can begin a load sequence. When dir_right is 0, only start_l_in can. A pulse on the unselected pin changes nothing.
- R3: When dir_right is 1, start_l_oe is 1 and start_r_oe is 0, and start_r_out is held at 0. When dir_right is 0, the roles of the two pins are swapped. Exactly one enable is high at any time.
- R4: A rising clock edge that samples the selected start pin at 1 begins a sequence, and the word present on that edge is not stored. The words on the 1st through 70th edges after it are stored as load positions 0 through 69.
- R5: When dir_right is 1, load position k is written to channel group k. When dir_right is 0, load position k is written to channel group 69-k, so the first word fills the highest group.
- R6: The cascade output of the active direction is 1 for exactly the one clock period that follows the 70th edge after the start edge. At all other times it is 0.
- R7: The sequence ends 72 edges after the start edge. From then on no further word changes row_data until a new start is sampled. A start sampled during a sequence restarts it at load position 0.
- R8: An edge that samples line_strobe at 1 after it was 0 stores no word and ends the sequence. After that, no word is stored and no cascade pulse is produced until the next start.
- R9: When inv_lo is 1, dots 0 to 2 of the stored word are the bitwise complement of the bus values. When inv_hi is 1, dots 3 to 5 are complemented. When a control is 0, its dots are stored unchanged. Both controls are sampled on the load edge.
- R10: A clock edge that samples rst_n at 0 clears row_data to zero, ends any sequence and drives both cascade outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_right | input | 1 | 1: token enters on the right pin and fills upward; 0: the opposite |
| start_r_in | input | 1 | Right start pin, input side |
| start_l_in | input | 1 | Left start pin, input side |
| start_r_out | output | 1 | Right start pin, cascade pulse out |
| start_r_oe | output | 1 | Right start pin output enable |
| start_l_out | output | 1 | Left start pin, cascade pulse out |
| start_l_oe | output | 1 | Left start pin output enable |
| line_strobe | input | 1 | Line strobe; its rising edge ends the sequence |
| inv_lo | input | 1 | Complement dots 0 to 2 on load |
| inv_hi | input | 1 | Complement dots 3 to 5 on load |
| pix_in | input | 36 | Six 6-bit dot codes |
| row_data | output | 2520 | Stored channel codes, group g at bits [36g+35:36g] |

## Verification
A word sampled on the k-th edge after the start edge appears in row_data right after that edge, so it is visible before the next edge. The cascade pulse rises right after the 70th edge and falls right after the 71st. A strobe or reset acts on the edge that samples it, with no extra delay. The bench changes its inputs 1 ns after each rising edge, so every input is stable when it is sampled. Its reference model advances on the rising edge. Every output is compared with the model on the falling edge, half a period after the register update that produced it.

// File: rtl/capture_pkg.sv
package capture_pkg;
    localparam int DOT_BITS      = 6;  // bits per dot code
    localparam int DOTS_PER_WORD = 6;  // dot codes per bus word
    localparam int STOP_MARGIN   = 2;  // extra clocks after the last position before the sequence ends
endpackage

// File: rtl/capture_token.sv
module capture_token #(
    parameter int POSITIONS  = 70,
    parameter int CASCADE_AT = 70,
    parameter int STOP_AT    = 72,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          strobe,
    output logic          load_en,
    output logic [CW-1:0] load_idx,
    output logic          casc
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;    // edges seen since the start edge, minus one
        logic          casc;
        logic          strb;   // strobe as seen on the previous edge
    } tok_t;

    tok_t          tok_d, tok_q;
    logic          strobe_rise;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        strobe_rise = strobe & ~tok_q.strb;
        cnt_inc     = tok_q.cnt + CW'(1);
        tok_d       = tok_q;
        tok_d.strb  = strobe;
        tok_d.casc  = 1'b0;
        if (start) begin
            tok_d.busy = 1'b1;
            tok_d.cnt  = '0;
        end else if (strobe_rise) begin
            tok_d.busy = 1'b0;
            tok_d.cnt  = '0;
        end else if (tok_q.busy) begin
            tok_d.cnt  = cnt_inc;
            tok_d.casc = (cnt_inc == CW'(CASCADE_AT));
            if (cnt_inc == CW'(STOP_AT)) begin
                tok_d.busy = 1'b0;
                tok_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= '0;
        else        tok_q <= tok_d;
    end

    assign load_en  = tok_q.busy & ~start & ~strobe_rise & (tok_q.cnt < CW'(POSITIONS));
    assign load_idx = tok_q.cnt;
    assign casc     = tok_q.casc;
endmodule

// File: rtl/capture_invert.sv
module capture_invert #(
    parameter int DOT_W = 6,
    parameter int DOTS  = 6
) (
    input  logic [DOTS*DOT_W-1:0] raw,
    input  logic                  inv_lo,
    input  logic                  inv_hi,
    output logic [DOTS*DOT_W-1:0] cooked
);
    localparam int HALF = DOTS / 2;

    for (genvar d = 0; d < DOTS; d++) begin : g_dot
        if (d < HALF) begin : g_lo
            assign cooked[d*DOT_W +: DOT_W] = raw[d*DOT_W +: DOT_W] ^ {DOT_W{inv_lo}};
        end else begin : g_hi
            assign cooked[d*DOT_W +: DOT_W] = raw[d*DOT_W +: DOT_W] ^ {DOT_W{inv_hi}};
        end
    end
endmodule

// File: rtl/capture_store.sv
module capture_store #(
    parameter int POSITIONS = 70,
    parameter int WORD_W    = 36,
    parameter int CW        = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [CW-1:0]                 load_idx,
    input  logic                          fill_up,
    input  logic [WORD_W-1:0]             word,
    output logic [POSITIONS*WORD_W-1:0]   row
);
    localparam int ROW_W = POSITIONS * WORD_W;

    logic [ROW_W-1:0] row_d, row_q;
    int               grp;

    always_comb begin
        grp   = fill_up ? int'(load_idx) : (POSITIONS - 1 - int'(load_idx));
        row_d = row_q;
        if (load_en) row_d[grp*WORD_W +: WORD_W] = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;
endmodule

// File: rtl/column_capture.sv
module column_capture
    import capture_pkg::*;
#(
    parameter int POSITIONS  = 70,
    parameter int CASCADE_AT = 70,
    parameter int DOT_W      = DOT_BITS,
    parameter int DOTS       = DOTS_PER_WORD
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              dir_right,
    input  logic                              start_r_in,
    input  logic                              start_l_in,
    output logic                              start_r_out,
    output logic                              start_r_oe,
    output logic                              start_l_out,
    output logic                              start_l_oe,
    input  logic                              line_strobe,
    input  logic                              inv_lo,
    input  logic                              inv_hi,
    input  logic [DOTS*DOT_W-1:0]             pix_in,
    output logic [POSITIONS*DOTS*DOT_W-1:0]   row_data
);
    localparam int WORD_W  = DOTS * DOT_W;
    localparam int STOP_AT = POSITIONS + STOP_MARGIN;
    localparam int CW      = $clog2(STOP_AT + 1);

    logic              start_sel;
    logic              load_en;
    logic [CW-1:0]     load_idx;
    logic              casc;
    logic [WORD_W-1:0] word_c;

    // The token enters on one pin and leaves on the other.
    assign start_sel   = dir_right ? start_r_in : start_l_in;
    assign start_l_oe  = dir_right;
    assign start_r_oe  = ~dir_right;
    assign start_l_out = dir_right & casc;
    assign start_r_out = ~dir_right & casc;

    capture_token #(
        .POSITIONS(POSITIONS), .CASCADE_AT(CASCADE_AT), .STOP_AT(STOP_AT), .CW(CW)
    ) u_token (
        .clk(clk), .rst_n(rst_n), .start(start_sel), .strobe(line_strobe),
        .load_en(load_en), .load_idx(load_idx), .casc(casc)
    );

    capture_invert #(.DOT_W(DOT_W), .DOTS(DOTS)) u_invert (
        .raw(pix_in), .inv_lo(inv_lo), .inv_hi(inv_hi), .cooked(word_c)
    );

    capture_store #(.POSITIONS(POSITIONS), .WORD_W(WORD_W), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .fill_up(dir_right), .word(word_c), .row(row_data)
    );
endmodule

// File: rtl/column_capture_chk.sv
module column_capture_chk #(
    parameter int POSITIONS = 70,
    parameter int ROW_W     = 2520
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dir_right,
    input logic             start_r_in,
    input logic             start_l_in,
    input logic             line_strobe,
    input logic             start_r_out,
    input logic             start_l_out,
    input logic             start_r_oe,
    input logic             start_l_oe,
    input logic [ROW_W-1:0] row_data
);
    localparam int SAT = POSITIONS + 4;

    logic start_now;
    logic strobe_prev;
    int   since;

    assign start_now = dir_right ? start_r_in : start_l_in;

    // Independent count of edges since the last start, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since       <= SAT;
            strobe_prev <= 1'b0;
        end else begin
            strobe_prev <= line_strobe;
            if (start_now)      since <= 0;
            else if (since < SAT) since <= since + 1;
        end
    end

    AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_r_oe, start_l_oe}) == 1); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_r_out | start_l_out) |=> !(start_r_out | start_l_out)); // R6

    AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= POSITIONS && !start_now) |=> $stable(row_data)); // R7

    AST_STROBE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !strobe_prev && !start_now) |=> $stable(row_data)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (row_data == '0 && !start_r_out && !start_l_out)); // R10
endmodule

bind column_capture column_capture_chk #(
    .POSITIONS(POSITIONS), .ROW_W(POSITIONS*DOTS*DOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .start_r_in(start_r_in),
    .start_l_in(start_l_in), .line_strobe(line_strobe), .start_r_out(start_r_out),
    .start_l_out(start_l_out), .start_r_oe(start_r_oe), .start_l_oe(start_l_oe),
    .row_data(row_data)
);

// File: tb/column_capture_test.sv
`timescale 1ns/1ps
module column_capture_test;
    localparam int P  = 70;
    localparam int DW = 6;
    localparam int ND = 6;
    localparam int WW = DW * ND;
    localparam int RW = P * WW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0, dir_right = 1'b1, sr = 1'b0, sl = 1'b0;
    logic          strobe = 1'b0, inv_lo = 1'b0, inv_hi = 1'b0;
    logic [WW-1:0] pix = '0;
    logic          start_r_out, start_r_oe, start_l_out, start_l_oe;
    logic [RW-1:0] row_data;

    column_capture uut (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .start_r_in(sr), .start_l_in(sl),
        .start_r_out(start_r_out), .start_r_oe(start_r_oe), .start_l_out(start_l_out),
        .start_l_oe(start_l_oe), .line_strobe(strobe), .inv_lo(inv_lo), .inv_hi(inv_hi),
        .pix_in(pix), .row_data(row_data)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R10";
    bit    cmp_on = 1'b0;

    // Reference model state
    int            m_since = -1;
    logic          m_casc = 1'b0, m_strb = 1'b0;
    logic [RW-1:0] m_row = '0;

    function automatic logic [WW-1:0] word_of(int i);
        logic [WW-1:0] w;
        for (int d = 0; d < ND; d++) w[d*DW +: DW] = DW'((i * 7 + d * 11 + 3) % 64);
        return w;
    endfunction

    task automatic check(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic feed(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            pix = word_of(base + i);
            step();
        end
    endtask

    function automatic logic [WW-1:0] grp_of(input logic [RW-1:0] r, input int g);
        return r[g*WW +: WW];
    endfunction

    always @(posedge clk) begin : model
        logic          st, rise;
        logic [WW-1:0] wv;
        int            g;
        if (!rst_n) begin
            m_since = -1; m_casc = 1'b0; m_strb = 1'b0; m_row = '0;
        end else begin
            st     = dir_right ? sr : sl;
            rise   = strobe && !m_strb;
            m_strb = strobe;
            m_casc = 1'b0;
            if (st) m_since = 0;
            else if (rise) m_since = -1;
            else if (m_since >= 0) begin
                if (m_since < P) begin
                    wv = pix;
                    for (int d = 0; d < ND; d++)
                        if ((d < ND / 2) ? inv_lo : inv_hi) wv[d*DW +: DW] = ~wv[d*DW +: DW];
                    g = dir_right ? m_since : (P - 1 - m_since);
                    m_row[g*WW +: WW] = wv;
                end
                m_since++;
                if (m_since == 70) m_casc = 1'b1;
                if (m_since >= P + 2) m_since = -1;
            end
        end
    end

    always @(negedge clk) begin : compare
        int bad;
        if (cmp_on) begin
            bad = -1;
            for (int g = P - 1; g >= 0; g--)
                if (grp_of(row_data, g) !== grp_of(m_row, g)) bad = g;
            if (bad < 0) check(cur_req, 1'b1, 0, 0);
            else check(cur_req, 1'b0, 64'(grp_of(row_data, bad)), 64'(grp_of(m_row, bad)));
            check("R6", {start_l_out, start_r_out} === {dir_right & m_casc, ~dir_right & m_casc},
                  64'({start_l_out, start_r_out}), 64'({dir_right & m_casc, ~dir_right & m_casc}));
            check("R3", {start_r_oe, start_l_oe} === {~dir_right, dir_right},
                  64'({start_r_oe, start_l_oe}), 64'({~dir_right, dir_right}));
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [RW-1:0] snap;
        logic [WW-1:0] w;
        step();
        cmp_on = 1'b1;
        repeat (3) step();
        check("R10", row_data == '0 && !start_l_out && !start_r_out, 64'(row_data[63:0]), 0);
        rst_n = 1'b1;
        step();

        // Right fill, full window and beyond
        cur_req = "R4";
        dir_right = 1'b1; sr = 1'b1; pix = word_of(999); step(); sr = 1'b0;
        for (int i = 0; i < 80; i++) begin
            pix = word_of(i);
            step();
            if (i == 69) check("R6", start_l_out === 1'b1, 64'(start_l_out), 1);
            if (i == 70) check("R6", start_l_out === 1'b0, 64'(start_l_out), 0);
        end
        w = word_of(0);
        check("R1", row_data[2*DW +: DW] == w[2*DW +: DW], 64'(row_data[2*DW +: DW]), 64'(w[2*DW +: DW]));
        check("R4", grp_of(row_data, 0) == word_of(0), 64'(grp_of(row_data, 0)), 64'(word_of(0)));
        check("R7", grp_of(row_data, P-1) == word_of(P-1), 64'(grp_of(row_data, P-1)), 64'(word_of(P-1)));

        // Unselected start pin
        cur_req = "R2";
        sl = 1'b1; step(); sl = 1'b0;
        feed(10, 200);
        check("R2", grp_of(row_data, 0) == word_of(0), 64'(grp_of(row_data, 0)), 64'(word_of(0)));

        // Per-half inversion
        cur_req = "R9";
        sr = 1'b1; step(); sr = 1'b0;
        for (int i = 0; i < P + 3; i++) begin
            inv_lo = i[0]; inv_hi = i[1];
            pix = word_of(300 + i);
            step();
        end
        inv_lo = 1'b0; inv_hi = 1'b0;
        check("R9", grp_of(row_data, 3) == ~word_of(303), 64'(grp_of(row_data, 3)), 64'(~word_of(303)));
        w = word_of(301);
        check("R9", grp_of(row_data, 1) == {w[WW-1:WW/2], ~w[WW/2-1:0]},
              64'(grp_of(row_data, 1)), 64'({w[WW-1:WW/2], ~w[WW/2-1:0]}));

        // Left fill
        cur_req = "R5";
        dir_right = 1'b0; sl = 1'b1; step(); sl = 1'b0;
        feed(75, 400);
        check("R5", grp_of(row_data, P-1) == word_of(400), 64'(grp_of(row_data, P-1)), 64'(word_of(400)));
        check("R5", grp_of(row_data, 0) == word_of(400+P-1), 64'(grp_of(row_data, 0)), 64'(word_of(400+P-1)));

        // Strobe ends the sequence early
        cur_req = "R8";
        dir_right = 1'b1; sr = 1'b1; step(); sr = 1'b0;
        feed(10, 500);
        snap = row_data;
        strobe = 1'b1; pix = word_of(510); step(); strobe = 1'b0;
        feed(80, 511);
        check("R8", row_data == snap, 64'(grp_of(row_data, 10)), 64'(grp_of(snap, 10)));

        // Restart mid-sequence
        cur_req = "R7";
        sr = 1'b1; step(); sr = 1'b0;
        feed(20, 600);
        sr = 1'b1; pix = word_of(620); step(); sr = 1'b0;
        feed(75, 700);
        check("R7", grp_of(row_data, 0) == word_of(700), 64'(grp_of(row_data, 0)), 64'(word_of(700)));

        // Reset during a sequence
        cur_req = "R10";
        sr = 1'b1; step(); sr = 1'b0;
        feed(5, 800);
        rst_n = 1'b0; step(); step();
        check("R10", row_data == '0, 64'(row_data[63:0]), 0);
        rst_n = 1'b1;
        feed(5, 900);
        check("R10", row_data == '0, 64'(row_data[63:0]), 0);

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule